// File: doc/BRIEF.md
# Phase-Offset Edge-Placement PWM

This block generates a group of pulse-width-modulated outputs that all run from one shared up-counting timebase held inside the block. The timebase counts from zero up to one less than the period, then wraps. Its current count is also driven out, so neighbouring logic can follow the same timebase. The period is taken from a live input, but only at the wrap point. Because every channel shares this timebase, a period change reaches all channels at the same wrap.

Each channel has its own offset and width, set through a single write port. The pulse starts when the counter reaches the channel's offset. It lasts for the channel's width in counts, so it ends at offset plus width. A write is checked against the period that the timebase will load at its next wrap. A write whose offset plus width is larger than that period is dropped. An accepted write is held in a shadow set and moves into the live set only at the wrap, so a pulse is never cut in the middle of a period. Each channel also has a polarity bit that selects whether it is active-high or active-low.

Top module: `edgeplace_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter goes to 0 and the period goes to `RST_PERIOD`. Every channel's live and shadow offset and width go to 0, and its polarity goes to active-high (0). As a result, every output is 0.
- R2: The counter steps by one each cycle. In the cycle where it equals the live period minus one, it wraps to 0 on the next edge. At that same edge, the live period is loaded from `period_i`. A `period_i` value below 2 is loaded as 2.
- R3: With polarity 0, a channel output is 1 exactly when offset <= count < offset + width. Otherwise the output is 0.
- R4: A width of 0 keeps the channel at its inactive level for the whole period.
- R5: A write with offset + width greater than the effective `period_i` (values below 2 count as 2) in the write cycle is dropped. Both the shadow and the live settings of that channel stay unchanged.
- R6: An accepted write is copied to the live set at the first wrap edge after the write edge. A write sampled in the wrap cycle itself is stored in the shadow set, so it goes live one full period later.
- R7: A change of `period_i` affects no channel before the next wrap. At that wrap it takes effect for all channels at the same time.
- R8: Polarity bit 1 (active-low) inverts the channel output: the output is 0 inside the window and 1 outside it.
- R9: A write changes only the channel selected by `wr_ch_i`. A write to an index of `NUM_CH` or more changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_i | input | CNT_W | Period in counts; loaded at the wrap |
| wr_i | input | 1 | Write strobe for one channel's settings |
| wr_ch_i | input | CH_W | Index of the channel to write |
| phase_i | input | CNT_W | Offset of the leading edge |
| duty_i | input | CNT_W | Pulse width in counts |
| pol_i | input | 1 | Polarity: 0 active-high, 1 active-low |
| cnt_o | output | CNT_W | Current timebase count |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
Two events can fall in the same cycle: a settings write and the timebase wrap. The bench places writes exactly in the wrap cycle, and also places period changes in the middle of a period. A cycle-by-cycle arithmetic model, built from the requirements, predicts the results. The model expects a write made in the wrap cycle to skip the wrap that coincides with it. The bench compares the count and every output against this model on each falling edge.

// File: rtl/epw_pkg.sv
// Shared types for the edge-placement PWM.
// Assumes: the polarity encoding below is the one used on pol_i.
package epw_pkg;
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/epw_timebase.sv
// Shared up-counting timebase.
// Counts 0 .. per-1, then wraps. The period is loaded from period_i only at
// the wrap. Assumes period_i is synchronous to clk. Values below 2 are
// raised to 2.
module epw_timebase #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned RST_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o,
    output logic             bnd_o
);
    import epw_pkg::*;

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] RST_P = CNT_W'(RST_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_eff;

    // Clamp the requested period to the smallest usable value.
    always_comb begin
        per_eff = (period_i < MIN_P) ? MIN_P : period_i;
    end

    // The wrap happens on the last count of the live period.
    always_comb begin
        bnd_o = (cnt_q == per_q - CNT_W'(1));
    end

    // Advance the count; at the wrap, restart and load the new period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= RST_P;
        end else if (bnd_o) begin
            cnt_q <= '0;
            per_q <= per_eff;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign lim_o = per_eff;

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_q);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_o |=> cnt_q == '0);
    assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_o |=> $stable(per_q));
endmodule

// File: rtl/epw_channel.sv
// One output channel with a phase offset.
// Writes that fit the upcoming period go into a shadow set. The shadow set
// is copied to the live set at the timebase wrap. The output is active while
// offset <= count < offset + width.
// Assumes cnt_i, bnd_i and lim_i come from the shared timebase.
module epw_channel #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             bnd_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             pol_i,
    output logic             pwm_o
);
    import epw_pkg::*;

    logic [CNT_W-1:0] sh_ph, sh_du, lv_ph, lv_du;
    pol_e             sh_pol, lv_pol;
    logic             fit;
    logic             win;
    logic [CNT_W:0]   lv_end;

    // A write fits when its trailing edge lands inside the upcoming period.
    always_comb begin
        fit = ({1'b0, phase_i} + {1'b0, duty_i}) <= {1'b0, lim_i};
    end

    // Hold each accepted write in the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ph  <= '0;
            sh_du  <= '0;
            sh_pol <= POL_HIGH;
        end else if (wr_i && fit) begin
            sh_ph  <= phase_i;
            sh_du  <= duty_i;
            sh_pol <= pol_e'(pol_i);
        end
    end

    // Copy the shadow set to the live set at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_ph  <= '0;
            lv_du  <= '0;
            lv_pol <= POL_HIGH;
        end else if (bnd_i) begin
            lv_ph  <= sh_ph;
            lv_du  <= sh_du;
            lv_pol <= sh_pol;
        end
    end

    // Find the active window and apply the polarity.
    always_comb begin
        lv_end = {1'b0, lv_ph} + {1'b0, lv_du};
        win    = (cnt_i >= lv_ph) && ({1'b0, cnt_i} < lv_end);
        pwm_o  = win ^ (lv_pol == POL_LOW);
    end

    assert_zero_width_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_du == '0) |-> (pwm_o == (lv_pol == POL_LOW)));
    assert_lead_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o != (lv_pol == POL_LOW)) |-> (cnt_i >= lv_ph));
    assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !fit) |=> ($stable(sh_ph) && $stable(sh_du) && $stable(sh_pol)));
    assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |=> ($stable(lv_ph) && $stable(lv_du) && $stable(lv_pol)));
endmodule

// File: rtl/edgeplace_pwm.sv
// Top level: one shared timebase and NUM_CH phase-offset channels.
// Decodes the write index to one channel. Indexes of NUM_CH or more select
// no channel. Assumes all inputs are synchronous to clk.
module edgeplace_pwm #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned RST_PERIOD = 16,
    localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              wr_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic [CNT_W-1:0]  phase_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic              pol_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [CNT_W-1:0] tb_cnt;
    logic [CNT_W-1:0] tb_lim;
    logic             tb_bnd;

    epw_timebase #(
        .CNT_W      (CNT_W),
        .RST_PERIOD (RST_PERIOD)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .cnt_o    (tb_cnt),
        .lim_o    (tb_lim),
        .bnd_o    (tb_bnd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_sel;

        // Route the strobe only to the addressed channel.
        always_comb begin
            wr_sel = wr_i && (wr_ch_i == CH_W'(c));
        end

        epw_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_i   (tb_cnt),
            .bnd_i   (tb_bnd),
            .lim_i   (tb_lim),
            .wr_i    (wr_sel),
            .phase_i (phase_i),
            .duty_i  (duty_i),
            .pol_i   (pol_i),
            .pwm_o   (pwm_o[c])
        );
    end

    assign cnt_o = tb_cnt;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (tb_cnt == '0 && pwm_o == '0));
endmodule

// File: tb/edgeplace_pwm_tb.sv
module edgeplace_pwm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int NCH = 3;
    localparam int CH_W = 2;
    localparam int RSTP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] period_i = CNT_W'(6);
    logic wr_i = 1'b0;
    logic [CH_W-1:0] wr_ch_i = '0;
    logic [CNT_W-1:0] phase_i = '0;
    logic [CNT_W-1:0] duty_i = '0;
    logic pol_i = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic [NCH-1:0] pwm_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_cnt, m_per;
    int m_sph[NCH], m_sdu[NCH], m_spol[NCH];
    int m_aph[NCH], m_adu[NCH], m_apol[NCH];

    edgeplace_pwm #(.CNT_W(CNT_W), .NUM_CH(NCH), .RST_PERIOD(RSTP)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .wr_i(wr_i),
        .wr_ch_i(wr_ch_i), .phase_i(phase_i), .duty_i(duty_i), .pol_i(pol_i),
        .cnt_o(cnt_o), .pwm_o(pwm_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Arithmetic reference model built from the requirements.
    always @(posedge clk) begin
        int eff;
        if (!rst_n) begin
            m_cnt <= 0;
            m_per <= RSTP;
            for (int c = 0; c < NCH; c++) begin
                m_sph[c] <= 0; m_sdu[c] <= 0; m_spol[c] <= 0;
                m_aph[c] <= 0; m_adu[c] <= 0; m_apol[c] <= 0;
            end
        end else begin
            eff = (int'(period_i) < 2) ? 2 : int'(period_i);
            if (m_cnt == m_per - 1) begin
                m_cnt <= 0;
                m_per <= eff;
                for (int c = 0; c < NCH; c++) begin
                    m_aph[c] <= m_sph[c]; m_adu[c] <= m_sdu[c]; m_apol[c] <= m_spol[c];
                end
            end else begin
                m_cnt <= m_cnt + 1;
            end
            if (wr_i && int'(wr_ch_i) < NCH && int'(phase_i) + int'(duty_i) <= eff) begin
                m_sph[wr_ch_i] <= int'(phase_i);
                m_sdu[wr_ch_i] <= int'(duty_i);
                m_spol[wr_ch_i] <= int'(pol_i);
            end
        end
    end

    // Compare count and every output away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (int'(cnt_o) != m_cnt) begin
                bad++;
                $display("FAIL R2 count: actual=%0d expected=%0d", cnt_o, m_cnt);
            end
            for (int c = 0; c < NCH; c++) begin
                int win, exp_v;
                win = (m_cnt >= m_aph[c] && m_cnt < m_aph[c] + m_adu[c]) ? 1 : 0;
                exp_v = win ^ m_apol[c];
                total++;
                if (int'(pwm_o[c]) != exp_v) begin
                    bad++;
                    $display("FAIL %s ch%0d cnt=%0d: actual=%0d expected=%0d",
                             cur_req, c, m_cnt, pwm_o[c], exp_v);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_cnt(input int v);
        do begin
            @(posedge clk); #1;
        end while (int'(cnt_o) != v);
    endtask

    // The strobe is raised just after an edge and sampled at the next edge.
    task automatic wr(input int ch, input int ph, input int du, input int pol);
        wr_i = 1'b1; wr_ch_i = CH_W'(ch);
        phase_i = CNT_W'(ph); duty_i = CNT_W'(du); pol_i = pol[0];
        @(posedge clk); #1;
        wr_i = 1'b0;
    endtask

    initial begin
        // R1: reset state is checked by the compare process during reset.
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(1);
        wr(1, 4, 2, 0);
        // R3 / R4 / R5: sweep channel 0 offset and width at period 6.
        for (int ph = 0; ph <= 7; ph++) begin
            for (int du = 0; du <= 7; du++) begin
                if (du == 0) cur_req = "R4";
                else if (ph + du > 6) cur_req = "R5";
                else cur_req = "R3";
                wait_cnt(2);
                wr(0, ph, du, 0);
                idle(14);
            end
        end
        // R8: active-low sweep on channel 2.
        cur_req = "R8";
        for (int ph = 0; ph <= 6; ph++) begin
            for (int du = 0; du <= 6 - ph; du++) begin
                wait_cnt(1);
                wr(2, ph, du, 1);
                idle(13);
            end
        end
        // R6: writes that land exactly in the wrap cycle.
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            wait_cnt(4);
            @(posedge clk); #1;
            wr(0, k, 2, 0);
            idle(3);
            wait_cnt(5);
            wr(0, k + 1, 1, k % 2);
            idle(14);
        end
        // R7 / R2: period changes mid-period reach all channels at one wrap.
        cur_req = "R7";
        wr(0, 1, 2, 0);
        wr(1, 3, 3, 0);
        idle(14);
        wait_cnt(2);
        period_i = CNT_W'(9);
        idle(30);
        wait_cnt(3);
        period_i = CNT_W'(4);
        idle(20);
        cur_req = "R2";
        period_i = CNT_W'(1);
        idle(12);
        period_i = CNT_W'(0);
        idle(8);
        period_i = CNT_W'(7);
        idle(20);
        // R9: writes to one channel or to an unused index.
        cur_req = "R9";
        wr(3, 0, 1, 1);
        idle(16);
        wr(1, 0, 7, 1);
        idle(16);
        wr(3, 2, 2, 0);
        idle(16);
        // R5: write that fits the old period but not the requested one.
        cur_req = "R5";
        period_i = CNT_W'(3);
        wr(2, 2, 3, 0);
        idle(20);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule